// File: doc/BRIEF.md
# Write Completion Status Reporter

This block owns the byte-wide read data path of a paged nonvolatile memory while the write controller is programming. As long as the controller reports busy, every read access returns a status byte instead of array contents. Bit 7 of that byte is the inverse of bit 7 of the byte most recently loaded, and bit 6 changes value after each completed read. Bits 5 to 0 echo the loaded byte. A host can therefore detect the end of programming in either of two ways. It can poll until bit 7 matches the value it wrote, or it can read twice and see whether bit 6 stopped changing.

Whether busy comes from a real programming cycle or from a write attempt blocked by software protection makes no difference. The block only sees the busy flag and reports status for as long as it is high. When busy falls, the output mux returns to true array data at once. The block also produces the output enable for the tri-state pad driver. That enable is active only during a genuine read strobe.

Top module: `wcs_reporter`

## Requirements
- R1: The output enable `dq_oe` is 1 exactly when `ce_n` is 0, `oe_n` is 0 and `we_n` is 1. While it is 0, `dq_out` is driven to all zeros.
- R2: During a read with `prog_busy` low, `dq_out` equals `arr_rdata`.
- R3: During a read with `prog_busy` high, bit 7 of `dq_out` is the complement of bit 7 of `last_wr`.
- R4: During a read with `prog_busy` high, bits 5..0 of `dq_out` equal bits 5..0 of `last_wr`.
- R5: During busy, bit 6 of `dq_out` is the toggle bit. It inverts on the first clock edge after each qualified read ends.
- R6: The toggle bit is forced to 0 on the first clock edge after `prog_busy` rises. The first poll of any busy period therefore reads 0 on bit 6.
- R7: In the same cycle that `prog_busy` falls, a read returns true array data on all eight bits.
- R8: A write strobe during busy (`ce_n`=0, `we_n`=0) is not a read. It does not invert the toggle bit.
- R9: After synchronous reset (`rst_n` low at a clock edge), the toggle bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_busy | input | 1 | Programming or timed write window in progress |
| last_wr | input | 8 | Last byte loaded by the write path |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| arr_rdata | input | 8 | Array read data |
| dq_out | output | 8 | Data driven towards the pads |
| dq_oe | output | 1 | Tri-state enable for the pads |

## Verification
The toggle bit is hard to reach in a known state, because it only moves when a read strobe has ended, one clock after the fact. It is also cleared by the rising edge of busy. The stimulus opens a busy period and waits one clock for the clear. It then issues back-to-back reads, each closed one clock before the next one opens, so that every poll sees the value after the previous inversion. It also slips a write strobe between two polls to show that bit 6 keeps its value across the write. A second busy period begins while the toggle bit holds 1, which proves that the clear happens at the rising edge of busy rather than at reset.

// File: rtl/wcs_pkg.sv
// Package: shared types for the write completion status reporter.
// Assumes: nothing beyond IEEE 1800-2017.
package wcs_pkg;
    // Which source the read mux forwards to the pads.
    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_STATUS = 1'b1
    } wcs_src_e;
endpackage

// File: rtl/wcs_strobe_qual.sv
// Module: wcs_strobe_qual
// Decodes the active-low strobes into a qualified read and flags the
// clock after a read access ends.
// Assumes: strobes are already synchronous to clk.
module wcs_strobe_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_act,
    output logic rd_end
);
    logic rd_q;

    // Qualified read: chip and output enabled, write strobe idle.
    always_comb begin
        rd_act = ~ce_n & ~oe_n & we_n;
    end

    // Remember last cycle's read state to find the trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_act;
    end

    // Pulse when a read that was active has just finished.
    always_comb begin
        rd_end = rd_q & ~rd_act;
    end
endmodule

// File: rtl/wcs_toggle_gen.sv
// Module: wcs_toggle_gen
// Holds the toggle status bit: cleared at the start of each busy period,
// inverted after every finished read while busy.
// Assumes: rd_end is a single-cycle pulse from wcs_strobe_qual.
module wcs_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_end,
    output logic toggle_q
);
    logic busy_q;
    logic busy_start;

    // Delay busy by one clock to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Rising edge of busy marks a new programming window.
    always_comb begin
        busy_start = busy & ~busy_q;
    end

    // Toggle state: a new window clears it, a finished poll inverts it.
    always_ff @(posedge clk) begin
        if (!rst_n)               toggle_q <= 1'b0;
        else if (busy_start)      toggle_q <= 1'b0;
        else if (busy && rd_end)  toggle_q <= ~toggle_q;
    end
endmodule

// File: rtl/wcs_status_mux.sv
// Module: wcs_status_mux
// Builds the status byte and selects between status and array data.
// Assumes: POLL_BIT and TOGGLE_BIT are distinct and below DATA_W.
module wcs_status_mux #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              busy,
    input  logic              rd_act,
    input  logic              toggle_q,
    input  logic [DATA_W-1:0] last_wr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    import wcs_pkg::*;

    logic [DATA_W-1:0] status_byte;
    wcs_src_e          src;

    // Assemble the status byte one bit at a time.
    for (genvar i = 0; i < DATA_W; i++) begin : g_stat
        if (i == POLL_BIT) begin : g_poll
            assign status_byte[i] = ~last_wr[i];
        end else if (i == TOGGLE_BIT) begin : g_tgl
            assign status_byte[i] = toggle_q;
        end else begin : g_echo
            assign status_byte[i] = last_wr[i];
        end
    end

    // Pick the data source from the busy flag.
    always_comb begin
        src = busy ? SRC_STATUS : SRC_ARRAY;
    end

    // Drive the pads only during a qualified read; zeros otherwise.
    always_comb begin
        dq_oe = rd_act;
        if (!rd_act)                dq_out = '0;
        else if (src == SRC_STATUS) dq_out = status_byte;
        else                        dq_out = arr_rdata;
    end
endmodule

// File: rtl/wcs_reporter.sv
// Module: wcs_reporter (top)
// Read-side status reporter for a paged nonvolatile memory: returns a
// polling/toggle status byte while prog_busy is high, array data otherwise.
// Assumes: prog_busy comes from the write controller and covers both real
// programming and protected (discarded) write windows.
module wcs_reporter #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] last_wr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic rd_act;
    logic rd_end;
    logic toggle_bit;

    wcs_strobe_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_act (rd_act),
        .rd_end (rd_end)
    );

    wcs_toggle_gen u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (prog_busy),
        .rd_end   (rd_end),
        .toggle_q (toggle_bit)
    );

    wcs_status_mux #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_mux (
        .busy      (prog_busy),
        .rd_act    (rd_act),
        .toggle_q  (toggle_bit),
        .last_wr   (last_wr),
        .arr_rdata (arr_rdata),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/wcs_reporter_chk.sv
// Module: wcs_reporter_chk
// Property checker for wcs_reporter, attached by the bind below.
// Assumes: default bit positions 7 (poll) and 6 (toggle).
module wcs_reporter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_busy,
    input logic [DATA_W-1:0] last_wr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              tgl
);
    logic rd_seen;
    assign rd_seen = !ce_n && !oe_n && we_n;

    AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0)); // R1
    AST_TRUE_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !prog_busy) |-> (dq_out == arr_rdata)); // R2
    AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && prog_busy) |-> (dq_out[7] == !last_wr[7])); // R3
    AST_LOW_BITS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && prog_busy) |-> (dq_out[5:0] == last_wr[5:0])); // R4
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy) && $past(rst_n) && $past(rd_seen) && !rd_seen)
        |=> (tgl != $past(tgl))); // R5
    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_busy) && $past(rst_n)) |=> (tgl == 1'b0)); // R6
    AST_WRITE_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy) && !$past(rd_seen)) |=> $stable(tgl)); // R8
endmodule

bind wcs_reporter wcs_reporter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_busy (prog_busy),
    .last_wr   (last_wr),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .tgl       (toggle_bit)
);

// File: tb/wcs_reporter_test.sv
// Directed bench for wcs_reporter: one task per scenario.
module wcs_reporter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_busy = 1'b0;
    logic [7:0] last_wr = 8'h00;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit exp_tgl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcs_reporter uut (
        .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .last_wr(last_wr),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .arr_rdata(arr_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected status byte from the requirements.
    function automatic logic [7:0] status_of(input logic [7:0] lw, input bit t);
        return {~lw[7], t, lw[5:0]};
    endfunction

    // One read access: open, sample, close; the toggle moves one edge later.
    task automatic do_read(input string req, input logic [7:0] exp);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check(req, {dq_oe, dq_out}, {1'b1, exp});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        if (prog_busy) exp_tgl = ~exp_tgl;
    endtask

    // Raise busy and give the clear one edge.
    task automatic start_busy(input logic [7:0] lw);
        @(negedge clk);
        prog_busy = 1'b1; last_wr = lw;
        @(negedge clk);
        exp_tgl = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset no drive", {dq_oe, dq_out}, 9'h000);
        exp_tgl = 1'b0;
        prog_busy = 1'b1; last_wr = 8'h2A;
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        // R9: toggle left at 0 by reset (busy rising here also clears it)
        check("R9 toggle zero after reset", {dq_oe, dq_out}, {1'b1, status_of(8'h2A, 1'b0)});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; prog_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_read;
        arr_rdata = 8'h5C;
        do_read("R2 idle array data", 8'h5C);
        arr_rdata = 8'hA3;
        do_read("R2 idle array data 2", 8'hA3);
    endtask

    task automatic t_highz;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; arr_rdata = 8'hFF;
        #1; check("R1 oe high", {dq_oe, dq_out}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b0;
        #1; check("R1 ce high", {dq_oe, dq_out}, 9'h000);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        #1; check("R1 we low", {dq_oe, dq_out}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic t_poll;
        arr_rdata = 8'h00;
        start_busy(8'h95);
        do_read("R3 R4 R6 first poll", status_of(8'h95, 1'b0));
        do_read("R5 second poll", status_of(8'h95, 1'b1));
        do_read("R5 third poll", status_of(8'h95, 1'b0));
        last_wr = 8'h3F;
        do_read("R3 R4 new byte", status_of(8'h3F, exp_tgl));
    endtask

    task automatic t_write_ignored;
        bit held;
        held = exp_tgl;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        do_read("R8 write strobe no flip", status_of(last_wr, held));
    endtask

    task automatic t_restart;
        // exp_tgl is 1 here after the previous read; new window must clear
        @(negedge clk);
        prog_busy = 1'b0;
        @(negedge clk);
        start_busy(8'h00);
        do_read("R6 clear on new busy", status_of(8'h00, 1'b0));
    endtask

    task automatic t_end;
        @(negedge clk);
        arr_rdata = 8'h6E;
        prog_busy = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check("R7 true data at busy fall", {dq_oe, dq_out}, {1'b1, 8'h6E});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle_read();
                t_highz();
                t_poll();
                t_write_ignored();
                t_restart();
                t_end();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule